// File: doc/BRIEF.md
# ATA PIO Register Cycle Sequencer

This block is the host-side engine for single 8-bit programmed-I/O register accesses on a parallel ATA bus, clocked at 12 MHz. A client raises a request carrying a direction, a 5-bit device address and (for writes) a data byte. The sequencer accepts it only when idle and returns a one-cycle acknowledge. It then presents the address, asserts the read or write strobe, and checks the device ready line a fixed number of cycles into the strobe. It holds address and write data after the strobe negates, pads the cycle with recovery time up to a programmed floor, and finally pulses `done` with the captured read byte and an error flag.

Every phase length is a cycle count supplied on configuration inputs. The counts are latched when a request is accepted. A count of zero behaves as one. If the ready line is still low at the check point, the strobe stays asserted until ready is seen high. A wait timeout ends the cycle and reports an error. The data bus is split into an output, an input and a drive-enable. While reset is asserted every bus output enable is low, so the bus is released. The DMA acknowledge line is driven inactive at all times.

Top module: `ata_pio_seq`

## Requirements
- R1: While `rst` is high, `ide_ctl_oe` and `ide_dd_oe` are 0 from the first clock edge onward. After reset is released the idle bus is driven: `ide_ctl_oe`=1, both strobes high, and `ide_addr`=5'b11000. The address bit order is [4]=chip select 1 (active low), [3]=chip select 0 (active low), [2:0]=register address.
- R2: A request (`req_valid`=1) is accepted only in idle. `req_ack` is a one-cycle pulse in the cycle after the accepting edge. A request raised while a cycle is in progress gets no acknowledge until the cycle after `done`.
- R3: The request address is on `ide_addr` for S = max(`cfg_setup`,1) cycles before the strobe asserts. It stays there for H = max(`cfg_hold`,1) cycles after the strobe negates, then returns to 5'b11000.
- R4: Without a wait, the strobe is low for P = max(`cfg_active`,`cfg_tchk`,1) cycles. A read uses `ide_dior_n` and a write uses `ide_diow_n`. Both are never low together.
- R5: `ide_iordy` is sampled in the T-th strobe-low cycle, where T = max(`cfg_tchk`,1). If it is low there, the strobe is extended past P until a cycle in which `ide_iordy` is high. If it is high there, no wait is added.
- R6: On a read, `rdata` takes the value on `ide_dd_i` at the clock edge that negates the strobe. It holds that value until the next cycle's capture.
- R7: On a write, `ide_dd_oe`=1 and `ide_dd_o`=`req_wdata` from the start of setup to the end of hold. `ide_dd_oe`=0 at every other time and throughout reads.
- R8: Counting the acknowledge cycle as 0, `done` rises L = max(S+P+W+H+R, C) cycles later. Here W is the number of wait cycles, R = max(`cfg_recover`,1) and C = `cfg_cycle`.
- R9: If `ide_iordy` stays low for max(`cfg_wait_max`,1) wait cycles, the strobe is negated and the cycle completes with `err`=1 and `rdata`=0. A normally completed cycle has `err`=0.
- R10: `ide_dmack_n` is 1 whenever the control outputs are driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 12 MHz clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; held until acknowledged |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_addr | input | 5 | {CS1 active low, CS0 active low, register address[2:0]} |
| req_wdata | input | DATA_W | Write byte |
| req_ack | output | 1 | One-cycle acceptance pulse |
| cfg_setup | input | CNT_W | Address-to-strobe setup cycles |
| cfg_active | input | CNT_W | Minimum strobe-low cycles |
| cfg_tchk | input | CNT_W | Strobe cycle in which ready is checked |
| cfg_hold | input | CNT_W | Address/data hold cycles after strobe |
| cfg_recover | input | CNT_W | Minimum recovery cycles |
| cfg_cycle | input | CYC_W | Minimum total cycle length |
| cfg_wait_max | input | WAIT_W | Wait cycles before timeout |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Timeout flag, valid with `done` |
| rdata | output | DATA_W | Captured read byte |
| ide_ctl_oe | output | 1 | Drive enable for address, strobes and DMA acknowledge |
| ide_addr | output | 5 | Bus address and chip selects |
| ide_dior_n | output | 1 | Read strobe, active low |
| ide_diow_n | output | 1 | Write strobe, active low |
| ide_dmack_n | output | 1 | DMA acknowledge, held inactive |
| ide_dd_oe | output | 1 | Data bus drive enable |
| ide_dd_o | output | DATA_W | Data bus output value |
| ide_dd_i | input | DATA_W | Data bus input value |
| ide_iordy | input | 1 | Device ready |

## Verification
The acknowledge appears one cycle after the accepting edge, and every later result is timed from that cycle as cycle 0. The address is up for S cycles, the strobe is low for P or for the cycle in which ready rises, hold lasts H cycles, and `done` arrives at cycle L. The bench samples all outputs on falling edges and counts cycles from the acknowledge. It tallies each phase by observing the strobe and address pins, and compares the counts and `done` cycle with L worked out from the configuration values. Read data is changed on the bench side in the first hold cycle, which shows the capture happened on the strobe-negating edge. The busy-request test expects the second acknowledge exactly one cycle after `done`.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;

  localparam int ATA_ADDR_W = 5;
  // chip selects negated, register address zero
  localparam logic [ATA_ADDR_W-1:0] ATA_IDLE_ADDR = 5'b11000;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ACTIVE,
    ST_WAIT,
    ST_HOLD,
    ST_RECOVER
  } pio_state_e;

endpackage

// File: rtl/pio_phase_timer.sv
// Down counter that measures the length of one phase; a length of 0 acts as 1.
module pio_phase_timer #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] len_i,
  output logic [W-1:0] cnt_o,
  output logic         last_o
);

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= (len_i == '0) ? '0 : len_i - ONE;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == '0);

endmodule

// File: rtl/pio_wait_guard.sv
// Counts wait cycles and flags the last one allowed.
module pio_wait_guard #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         active_i,
  input  logic [W-1:0] limit_i,
  output logic         expire_o
);

  logic [W-1:0] cnt_q;
  logic [W:0]   nxt;

  assign nxt      = {1'b0, cnt_q} + {{W{1'b0}}, 1'b1};
  assign expire_o = active_i && (nxt >= {1'b0, limit_i});

  always_ff @(posedge clk) begin
    if (rst || !active_i) begin
      cnt_q <= '0;
    end else if (!expire_o) begin
      cnt_q <= nxt[W-1:0];
    end
  end

endmodule

// File: rtl/pio_cycle_floor.sv
// Tracks elapsed cycles of a transfer and reports when the minimum is met.
module pio_cycle_floor #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear_i,
  input  logic         run_i,
  input  logic [W-1:0] limit_i,
  output logic         met_o
);

  localparam logic [W-1:0] SAT = {W{1'b1}};

  logic [W-1:0] cnt_q;
  logic [W:0]   nxt;

  assign nxt   = {1'b0, cnt_q} + {{W{1'b0}}, 1'b1};
  assign met_o = (nxt >= {1'b0, limit_i});

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      cnt_q <= '0;
    end else if (run_i && cnt_q != SAT) begin
      cnt_q <= nxt[W-1:0];
    end
  end

endmodule

// File: rtl/ata_pio_seq.sv
module ata_pio_seq
  import ata_pio_pkg::*;
#(
  parameter int CNT_W  = 6,
  parameter int CYC_W  = 8,
  parameter int WAIT_W = 12,
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [ATA_ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  output logic                  req_ack,
  input  logic [CNT_W-1:0]      cfg_setup,
  input  logic [CNT_W-1:0]      cfg_active,
  input  logic [CNT_W-1:0]      cfg_tchk,
  input  logic [CNT_W-1:0]      cfg_hold,
  input  logic [CNT_W-1:0]      cfg_recover,
  input  logic [CYC_W-1:0]      cfg_cycle,
  input  logic [WAIT_W-1:0]     cfg_wait_max,
  output logic                  done,
  output logic                  err,
  output logic [DATA_W-1:0]     rdata,
  output logic                  ide_ctl_oe,
  output logic [ATA_ADDR_W-1:0] ide_addr,
  output logic                  ide_dior_n,
  output logic                  ide_diow_n,
  output logic                  ide_dmack_n,
  output logic                  ide_dd_oe,
  output logic [DATA_W-1:0]     ide_dd_o,
  input  logic [DATA_W-1:0]     ide_dd_i,
  input  logic                  ide_iordy
);

  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  pio_state_e state_q, state_d;

  // transfer context latched at acceptance
  logic                  wr_q;
  logic [ATA_ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0]     wdata_q;
  logic [CNT_W-1:0]      active_q, tchk_q, hold_q, recover_q;
  logic [CYC_W-1:0]      cycle_q;
  logic [WAIT_W-1:0]     waitmax_q;
  logic                  wait_flag_q;

  logic                  accept;
  logic [CNT_W-1:0]      a_eff, t_eff, p_eff;
  logic                  ta_hit, wait_now;
  logic                  tmr_load, tmr_last;
  logic [CNT_W-1:0]      tmr_len, tmr_cnt;
  logic                  wait_expire, floor_met;
  logic                  capture, timeout, finish;
  logic                  wr_d, strobe_d, busy_d;
  logic [ATA_ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0]     wdata_d;

  assign accept = (state_q == ST_IDLE) && req_valid;

  assign a_eff  = (active_q == '0) ? CNT_ONE : active_q;
  assign t_eff  = (tchk_q == '0) ? CNT_ONE : tchk_q;
  assign p_eff  = (a_eff > t_eff) ? a_eff : t_eff;
  // the phase counter runs p_eff-1 .. 0, so the T-th strobe cycle sits at p_eff-t_eff
  assign ta_hit   = (state_q == ST_ACTIVE) && (tmr_cnt == p_eff - t_eff);
  assign wait_now = wait_flag_q || (ta_hit && !ide_iordy);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (req_valid) state_d = ST_SETUP;
      ST_SETUP:   if (tmr_last) state_d = ST_ACTIVE;
      ST_ACTIVE:  if (tmr_last) state_d = wait_now ? ST_WAIT : ST_HOLD;
      ST_WAIT:    if (ide_iordy || wait_expire) state_d = ST_HOLD;
      ST_HOLD:    if (tmr_last) state_d = ST_RECOVER;
      ST_RECOVER: if (tmr_last && floor_met) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  assign capture = ((state_q == ST_ACTIVE) && tmr_last && !wait_now) ||
                   ((state_q == ST_WAIT) && ide_iordy);
  assign timeout = (state_q == ST_WAIT) && !ide_iordy && wait_expire;
  assign finish  = (state_q == ST_RECOVER) && tmr_last && floor_met;

  always_comb begin
    tmr_load = (state_d != state_q);
    unique case (state_d)
      ST_SETUP:   tmr_len = cfg_setup;
      ST_ACTIVE:  tmr_len = p_eff;
      ST_HOLD:    tmr_len = hold_q;
      ST_RECOVER: tmr_len = recover_q;
      default:    tmr_len = '0;
    endcase
  end

  pio_phase_timer #(.W(CNT_W)) u_phase (
    .clk    (clk),
    .rst    (rst),
    .load_i (tmr_load),
    .len_i  (tmr_len),
    .cnt_o  (tmr_cnt),
    .last_o (tmr_last)
  );

  pio_wait_guard #(.W(WAIT_W)) u_wait (
    .clk      (clk),
    .rst      (rst),
    .active_i (state_q == ST_WAIT),
    .limit_i  (waitmax_q),
    .expire_o (wait_expire)
  );

  pio_cycle_floor #(.W(CYC_W)) u_floor (
    .clk     (clk),
    .rst     (rst),
    .clear_i (accept),
    .run_i   (state_q != ST_IDLE),
    .limit_i (cycle_q),
    .met_o   (floor_met)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      wr_q        <= 1'b0;
      addr_q      <= ATA_IDLE_ADDR;
      wdata_q     <= '0;
      active_q    <= '0;
      tchk_q      <= '0;
      hold_q      <= '0;
      recover_q   <= '0;
      cycle_q     <= '0;
      waitmax_q   <= '0;
      wait_flag_q <= 1'b0;
      rdata       <= '0;
      err         <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        wr_q        <= req_write;
        addr_q      <= req_addr;
        wdata_q     <= req_wdata;
        active_q    <= cfg_active;
        tchk_q      <= cfg_tchk;
        hold_q      <= cfg_hold;
        recover_q   <= cfg_recover;
        cycle_q     <= cfg_cycle;
        waitmax_q   <= cfg_wait_max;
        wait_flag_q <= 1'b0;
        err         <= 1'b0;
      end else if (ta_hit && !ide_iordy) begin
        wait_flag_q <= 1'b1;
      end
      if (capture) begin
        rdata <= ide_dd_i;
      end else if (timeout) begin
        rdata <= '0;
        err   <= 1'b1;
      end
    end
  end

  // bus outputs are registered from the next state so they line up with state_q
  assign wr_d     = (state_q == ST_IDLE) ? req_write : wr_q;
  assign addr_d   = (state_q == ST_IDLE) ? req_addr  : addr_q;
  assign wdata_d  = (state_q == ST_IDLE) ? req_wdata : wdata_q;
  assign strobe_d = (state_d == ST_ACTIVE) || (state_d == ST_WAIT);
  assign busy_d   = strobe_d || (state_d == ST_SETUP) || (state_d == ST_HOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      ide_ctl_oe  <= 1'b0;
      ide_dd_oe   <= 1'b0;
      ide_dior_n  <= 1'b1;
      ide_diow_n  <= 1'b1;
      ide_dmack_n <= 1'b1;
      ide_addr    <= ATA_IDLE_ADDR;
      ide_dd_o    <= '0;
      req_ack     <= 1'b0;
      done        <= 1'b0;
    end else begin
      ide_ctl_oe  <= 1'b1;
      ide_dmack_n <= 1'b1;
      ide_dior_n  <= !(strobe_d && !wr_d);
      ide_diow_n  <= !(strobe_d && wr_d);
      ide_addr    <= busy_d ? addr_d : ATA_IDLE_ADDR;
      ide_dd_oe   <= busy_d && wr_d;
      ide_dd_o    <= wdata_d;
      req_ack     <= accept;
      done        <= finish;
    end
  end

endmodule

// File: rtl/ata_pio_seq_chk.sv
module ata_pio_seq_chk
  import ata_pio_pkg::*;
#(
  parameter int CNT_W  = 6,
  parameter int CYC_W  = 8,
  parameter int WAIT_W = 12,
  parameter int DATA_W = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  req_valid,
  input logic                  req_write,
  input logic [ATA_ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0]     req_wdata,
  input logic                  req_ack,
  input logic [CNT_W-1:0]      cfg_setup,
  input logic [CNT_W-1:0]      cfg_active,
  input logic [CNT_W-1:0]      cfg_tchk,
  input logic [CNT_W-1:0]      cfg_hold,
  input logic [CNT_W-1:0]      cfg_recover,
  input logic [CYC_W-1:0]      cfg_cycle,
  input logic [WAIT_W-1:0]     cfg_wait_max,
  input logic                  done,
  input logic                  err,
  input logic [DATA_W-1:0]     rdata,
  input logic                  ide_ctl_oe,
  input logic [ATA_ADDR_W-1:0] ide_addr,
  input logic                  ide_dior_n,
  input logic                  ide_diow_n,
  input logic                  ide_dmack_n,
  input logic                  ide_dd_oe,
  input logic [DATA_W-1:0]     ide_dd_o,
  input logic [DATA_W-1:0]     ide_dd_i,
  input logic                  ide_iordy
);

  a_r1_bus_released: assert property (@(posedge clk)
    rst |=> (!ide_ctl_oe && !ide_dd_oe));

  a_r2_ack_single: assert property (@(posedge clk) disable iff (rst)
    req_ack |=> !req_ack);

  a_r3_addr_steady: assert property (@(posedge clk) disable iff (rst)
    ((!ide_dior_n || !ide_diow_n) && $past(!ide_dior_n || !ide_diow_n)) |-> $stable(ide_addr));

  a_r3_addr_valid_strobe: assert property (@(posedge clk) disable iff (rst)
    (!ide_dior_n || !ide_diow_n) |-> (ide_addr[4:3] != 2'b11));

  a_r4_single_strobe: assert property (@(posedge clk) disable iff (rst)
    !(!ide_dior_n && !ide_diow_n));

  a_r7_no_drive_on_read: assert property (@(posedge clk) disable iff (rst)
    !ide_dior_n |-> !ide_dd_oe);

  a_r7_wdata_steady: assert property (@(posedge clk) disable iff (rst)
    (!ide_diow_n && $past(!ide_diow_n)) |-> $stable(ide_dd_o));

  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r9_timeout_zero: assert property (@(posedge clk) disable iff (rst)
    (done && err) |-> (rdata == '0));

  a_r10_dmack_idle: assert property (@(posedge clk) disable iff (rst)
    ide_ctl_oe |-> ide_dmack_n);

endmodule

bind ata_pio_seq ata_pio_seq_chk #(
  .CNT_W(CNT_W), .CYC_W(CYC_W), .WAIT_W(WAIT_W), .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/tb_ata_pio_seq.sv
module tb_ata_pio_seq;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;
  localparam logic [4:0] IDLE_A = 5'b11000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [4:0]  req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ack;
  logic [5:0]  cfg_setup = 6'd2, cfg_active = 6'd4, cfg_tchk = 6'd3;
  logic [5:0]  cfg_hold = 6'd2, cfg_recover = 6'd3;
  logic [7:0]  cfg_cycle = 8'd10;
  logic [11:0] cfg_wait_max = 12'd40;
  logic        done, err;
  logic [7:0]  rdata;
  logic        ide_ctl_oe, ide_dior_n, ide_diow_n, ide_dmack_n, ide_dd_oe;
  logic [4:0]  ide_addr;
  logic [7:0]  ide_dd_o;
  logic [7:0]  ide_dd_i = '0;
  logic        ide_iordy = 1'b1;

  int n_chk = 0, n_bad = 0;
  int m_s, m_low, m_h, m_len, m_other, m_abad, m_wbad, m_err;
  logic [7:0] m_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  ata_pio_seq dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ack(req_ack),
    .cfg_setup(cfg_setup), .cfg_active(cfg_active), .cfg_tchk(cfg_tchk),
    .cfg_hold(cfg_hold), .cfg_recover(cfg_recover), .cfg_cycle(cfg_cycle),
    .cfg_wait_max(cfg_wait_max), .done(done), .err(err), .rdata(rdata),
    .ide_ctl_oe(ide_ctl_oe), .ide_addr(ide_addr), .ide_dior_n(ide_dior_n),
    .ide_diow_n(ide_diow_n), .ide_dmack_n(ide_dmack_n), .ide_dd_oe(ide_dd_oe),
    .ide_dd_o(ide_dd_o), .ide_dd_i(ide_dd_i), .ide_iordy(ide_iordy)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // one transfer; raise_at = strobe-low cycle in which ready rises (0: never low)
  task automatic run_xfer(input bit wr, input logic [4:0] a, input logic [7:0] wd,
                          input logic [7:0] rd, input int raise_at);
    bit low, other, switched;
    int guard;
    @(negedge clk);
    ide_iordy = (raise_at == 0);
    ide_dd_i  = rd;
    req_write = wr; req_addr = a; req_wdata = wd; req_valid = 1'b1;
    guard = 0;
    do begin @(negedge clk); guard++; end while (!req_ack && guard < 50);
    req_valid = 1'b0;
    m_s = 0; m_low = 0; m_h = 0; m_len = -1; m_other = 0; m_abad = 0; m_wbad = 0;
    switched = 0;
    for (int k = 0; k < 5000; k++) begin
      if (k > 0) @(negedge clk);
      if (done) begin m_len = k; m_rdata = rdata; m_err = err; break; end
      low   = wr ? !ide_diow_n : !ide_dior_n;
      other = wr ? !ide_dior_n : !ide_diow_n;
      if (other) m_other++;
      if (low) begin
        m_low++;
        if (ide_addr != a) m_abad++;
        if (wr && (!ide_dd_oe || ide_dd_o != wd)) m_wbad++;
        if (!wr && ide_dd_oe) m_wbad++;
        if (m_low == raise_at) ide_iordy = 1'b1;
      end else if (ide_addr == a) begin
        if (m_low == 0) m_s++;
        else begin
          m_h++;
          if (wr && (!ide_dd_oe || ide_dd_o != wd)) m_wbad++;
          if (!switched) begin ide_dd_i = ~rd; switched = 1; end
        end
      end
    end
    ide_iordy = 1'b1;
  endtask

  task automatic set_cfg(input int s, input int a, input int t, input int h,
                         input int r, input int c, input int w);
    cfg_setup = 6'(s); cfg_active = 6'(a); cfg_tchk = 6'(t);
    cfg_hold = 6'(h); cfg_recover = 6'(r); cfg_cycle = 8'(c); cfg_wait_max = 12'(w);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 ctl_oe in reset", ide_ctl_oe, 0);
    check("R1 dd_oe in reset", ide_dd_oe, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 ctl_oe idle", ide_ctl_oe, 1);
    check("R1 strobes idle", {ide_dior_n, ide_diow_n}, 2'b11);
    check("R1 addr idle", ide_addr, IDLE_A);
    check("R10 dmack high", ide_dmack_n, 1);
    check("R2 no ack idle", req_ack, 0);
  endtask

  task automatic t_read_basic();
    set_cfg(2, 4, 3, 2, 3, 10, 40);
    run_xfer(1'b0, 5'b10010, 8'h00, 8'hA5, 0);
    check("R3 setup cycles", m_s, 2);
    check("R3 hold cycles", m_h, 2);
    check("R4 strobe width", m_low, 4);
    check("R4 other strobe", m_other, 0);
    check("R6 read data", m_rdata, 8'hA5);
    check("R8 cycle length", m_len, 11);
    check("R9 no error", m_err, 0);
    check("R7 no drive on read", m_wbad, 0);
    check("R3 addr during strobe", m_abad, 0);
  endtask

  task automatic t_write_basic();
    set_cfg(2, 4, 3, 2, 3, 10, 40);
    run_xfer(1'b1, 5'b10001, 8'h3C, 8'h00, 0);
    check("R7 write data driven", m_wbad, 0);
    check("R4 write strobe width", m_low, 4);
    check("R4 read strobe idle on write", m_other, 0);
    check("R8 write length", m_len, 11);
    check("R7 released after write", ide_dd_oe, 0);
    check("R3 addr back to idle", ide_addr, IDLE_A);
  endtask

  task automatic t_wait_extend();
    set_cfg(2, 4, 3, 2, 3, 10, 40);
    run_xfer(1'b0, 5'b01111, 8'h00, 8'h5A, 9);
    check("R5 extended strobe", m_low, 9);
    check("R6 read after wait", m_rdata, 8'h5A);
    check("R8 extended length", m_len, 16);
    check("R9 no error after wait", m_err, 0);
  endtask

  task automatic t_ready_before_check();
    set_cfg(2, 4, 3, 2, 3, 10, 40);
    run_xfer(1'b0, 5'b10011, 8'h00, 8'h11, 2);
    check("R5 ready by check no wait", m_low, 4);
    check("R8 no-wait length", m_len, 11);
  endtask

  task automatic t_timeout();
    set_cfg(2, 4, 3, 2, 3, 10, 5);
    run_xfer(1'b0, 5'b10100, 8'h00, 8'hFF, 10000);
    check("R9 timeout strobe width", m_low, 9);
    check("R9 timeout error", m_err, 1);
    check("R9 timeout data zero", m_rdata, 0);
    check("R8 timeout length", m_len, 16);
  endtask

  task automatic t_cycle_floor();
    set_cfg(2, 4, 3, 2, 3, 20, 40);
    run_xfer(1'b1, 5'b10101, 8'h77, 8'h00, 0);
    check("R8 floor length", m_len, 20);
    check("R4 floor strobe width", m_low, 4);
  endtask

  task automatic t_check_late();
    set_cfg(0, 1, 3, 1, 1, 0, 40);
    run_xfer(1'b0, 5'b10110, 8'h00, 8'hC3, 0);
    check("R3 zero setup acts as one", m_s, 1);
    check("R4 check beyond active", m_low, 3);
    check("R8 short length", m_len, 6);
    check("R6 short read", m_rdata, 8'hC3);
  endtask

  task automatic t_busy_request();
    int acks, guard, lenk;
    set_cfg(2, 4, 3, 2, 3, 10, 40);
    @(negedge clk);
    ide_iordy = 1'b1;
    req_write = 1'b0; req_addr = 5'b10111; req_valid = 1'b1;
    guard = 0;
    do begin @(negedge clk); guard++; end while (!req_ack && guard < 50);
    req_addr = 5'b01001;   // second request held while busy
    acks = 0; lenk = -1;
    for (int k = 1; k < 200; k++) begin
      @(negedge clk);
      if (k == 3) check("R3 first addr kept", ide_addr, 5'b10111);
      if (done) begin lenk = k; break; end
      if (req_ack) acks++;
    end
    check("R2 no ack while busy", acks, 0);
    check("R8 busy first length", lenk, 11);
    @(negedge clk);
    check("R2 ack after done", req_ack, 1);
    check("R2 second addr setup", ide_addr, 5'b01001);
    req_valid = 1'b0;
    guard = 0;
    do begin @(negedge clk); guard++; end while (!done && guard < 200);
    check("R2 second done", done, 1);
  endtask

  initial begin
    t_reset();
    t_read_basic();
    t_write_basic();
    t_wait_extend();
    t_ready_before_check();
    t_timeout();
    t_cycle_floor();
    t_check_late();
    t_busy_request();
    repeat (3) @(negedge clk);
    report();
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
    report();
    $finish;
  end

endmodule